// File: doc/BRIEF.md
# Non-volatile memory image checksum sequencer

This block walks a word-addressed non-volatile memory through a read port that takes one request at a time. It adds the returned 16-bit words with wraparound and then acts on the total. The memory side is reached only through two request/acknowledge ports, one for reads and one for writes. Each acknowledge carries an error flag, and a read acknowledge also carries the data word. Whatever serial protocol sits behind those ports is handled elsewhere.

A start pulse with the mode input low runs a check. The block reads every word from address 0 up to and including the checksum word. The image is good when the 16-bit total equals 0xBABA. A start pulse with the mode input high runs a repair. The block reads every word below the checksum word, works out the word that makes the image total 0xBABA, and writes that word to the checksum address in one write request. The checksum address is a parameter, 0x3F by default, and must be at least 1. When the operation ends, a one-cycle done pulse is given. The pass, fail and fault outputs then keep their values until the next accepted start.

Top module: `nvm_sum_checker`

## Requirements
- R1: After reset the block is idle: busy, read request, write request, done, pass, fail, read fault and write fault are all low.
- R2: The read request stays high with a stable address until an acknowledge arrives. Only one read is outstanding at any time. The address starts at 0 and goes up by exactly one after each error-free acknowledge.
- R3: In check mode, addresses 0 through CSUM_ADDR are each read once. The words are added modulo 2^16. Pass is set when the total is 0xBABA and fail is set for any other total.
- R4: In repair mode, only addresses 0 through CSUM_ADDR-1 are read. The checksum address itself is never read.
- R5: In repair mode, after the last read, exactly one write is issued to address CSUM_ADDR with data (0xBABA minus the partial sum) modulo 2^16. The write request and its data stay steady until acknowledged. Pass is set when the write acknowledge carries no error.
- R6: A read acknowledge with the error flag set ends the operation in the next cycle. No further read or write is issued, and done, fail and read fault are raised together.
- R7: A write acknowledge with the error flag set ends the operation in the next cycle with done, fail and write fault raised.
- R8: Done is high for exactly one cycle per operation. In that cycle exactly one of pass and fail is high. Pass, fail and both faults then hold their values until the next accepted start.
- R9: A start pulse that arrives while busy is high is ignored. It does not restart the walk, change the mode or add any access.
- R10: The mode input is sampled together with an accepted start. Value 0 selects check mode and value 1 selects repair mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 1 | 0 = check, 1 = repair; sampled with start |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_ack_i | input | 1 | Read acknowledge, one cycle |
| rd_data_i | input | WORD_W | Read data, valid with acknowledge |
| rd_err_i | input | 1 | Read error, valid with acknowledge |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write word address (always CSUM_ADDR) |
| wr_data_o | output | WORD_W | Checksum word to write |
| wr_ack_i | input | 1 | Write acknowledge, one cycle |
| wr_err_i | input | 1 | Write error, valid with acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded |
| fail_o | output | 1 | Checksum mismatch or access error |
| rd_fault_o | output | 1 | Operation ended on a read error |
| wr_fault_o | output | 1 | Operation ended on a write error |

## Verification
A corrupted address counter shows up at the read port at once. The very next request carries an address the memory model did not expect, or the total number of reads at done is wrong. A wrong accumulator value stays hidden until the final acknowledge, and then shows as a flipped pass/fail or as a wrong word on the write port. The bench compares both against totals it works out from its own copy of the memory. A state machine stuck in the wrong state shows as a missing or repeated done pulse, or as a write in check mode, within one operation.

// File: rtl/nvm_sum_pkg.sv
package nvm_sum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } walk_st_e;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_FIX   = 1'b1
    } walk_mode_e;

    typedef struct packed {
        walk_st_e   st;
        walk_mode_e mode;
        logic       pass;
        logic       fail;
        logic       rd_fault;
        logic       wr_fault;
    } walk_flags_t;

endpackage

// File: rtl/nvm_sum_acc.sv
module nvm_sum_acc #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] sum_o,
    output logic [WORD_W-1:0] sum_next_o
);

    logic [WORD_W-1:0] sum_d, sum_q;

    // Total including the word on word_i, wraps modulo 2^WORD_W
    assign sum_next_o = sum_q + word_i;
    assign sum_o      = sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_next_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

endmodule

// File: rtl/nvm_walk_fsm.sv
module nvm_walk_fsm
    import nvm_sum_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                WORD_W    = 16,
    parameter int                CSUM_ADDR = 'h3F,
    parameter logic [WORD_W-1:0] TARGET    = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic              wr_ack_i,
    input  logic              wr_err_i,
    input  logic [WORD_W-1:0] sum_next_i,
    output logic              acc_clr_o,
    output logic              acc_add_o,
    output logic              busy_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              rd_fault_o,
    output logic              wr_fault_o
);

    localparam logic [ADDR_W-1:0] LAST_CHECK = ADDR_W'(CSUM_ADDR);
    localparam logic [ADDR_W-1:0] LAST_FIX   = ADDR_W'(CSUM_ADDR - 1);

    walk_flags_t       f_d, f_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [WORD_W-1:0] wdata_d, wdata_q;
    logic [ADDR_W-1:0] last_addr;

    assign last_addr = (f_q.mode == MODE_FIX) ? LAST_FIX : LAST_CHECK;

    always_comb begin
        f_d       = f_q;
        addr_d    = addr_q;
        wdata_d   = wdata_q;
        acc_clr_o = 1'b0;
        acc_add_o = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    f_d.st       = ST_READ;
                    f_d.mode     = walk_mode_e'(mode_i);
                    f_d.pass     = 1'b0;
                    f_d.fail     = 1'b0;
                    f_d.rd_fault = 1'b0;
                    f_d.wr_fault = 1'b0;
                    addr_d       = '0;
                    acc_clr_o    = 1'b1;
                end
            end
            ST_READ: begin
                if (rd_ack_i) begin
                    if (rd_err_i) begin
                        f_d.st       = ST_DONE;
                        f_d.fail     = 1'b1;
                        f_d.rd_fault = 1'b1;
                    end else begin
                        acc_add_o = 1'b1;
                        if (addr_q == last_addr) begin
                            if (f_q.mode == MODE_FIX) begin
                                f_d.st  = ST_WRITE;
                                wdata_d = TARGET - sum_next_i;
                            end else begin
                                f_d.st   = ST_DONE;
                                f_d.pass = (sum_next_i == TARGET);
                                f_d.fail = (sum_next_i != TARGET);
                            end
                        end else begin
                            addr_d = addr_q + 1'b1;
                        end
                    end
                end
            end
            ST_WRITE: begin
                if (wr_ack_i) begin
                    f_d.st = ST_DONE;
                    if (wr_err_i) begin
                        f_d.fail     = 1'b1;
                        f_d.wr_fault = 1'b1;
                    end else begin
                        f_d.pass = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                f_d.st = ST_IDLE;
            end
            default: begin
                f_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q     <= '{st: ST_IDLE, mode: MODE_CHECK, default: 1'b0};
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            f_q     <= f_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    assign busy_o     = (f_q.st != ST_IDLE);
    assign rd_req_o   = (f_q.st == ST_READ);
    assign rd_addr_o  = addr_q;
    assign wr_req_o   = (f_q.st == ST_WRITE);
    assign wr_addr_o  = LAST_CHECK;
    assign wr_data_o  = wdata_q;
    assign done_o     = (f_q.st == ST_DONE);
    assign pass_o     = f_q.pass;
    assign fail_o     = f_q.fail;
    assign rd_fault_o = f_q.rd_fault;
    assign wr_fault_o = f_q.wr_fault;

endmodule

// File: rtl/nvm_sum_checker.sv
module nvm_sum_checker #(
    parameter int                ADDR_W    = 8,
    parameter int                WORD_W    = 16,
    parameter int                CSUM_ADDR = 'h3F,
    parameter logic [WORD_W-1:0] TARGET    = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    output logic              busy_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [WORD_W-1:0] rd_data_i,
    input  logic              rd_err_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    input  logic              wr_err_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              rd_fault_o,
    output logic              wr_fault_o
);

    logic              acc_clr;
    logic              acc_add;
    logic [WORD_W-1:0] acc_sum;
    logic [WORD_W-1:0] acc_next;

    nvm_sum_acc #(
        .WORD_W (WORD_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (acc_clr),
        .add_i      (acc_add),
        .word_i     (rd_data_i),
        .sum_o      (acc_sum),
        .sum_next_o (acc_next)
    );

    nvm_walk_fsm #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .CSUM_ADDR (CSUM_ADDR),
        .TARGET    (TARGET)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .rd_ack_i   (rd_ack_i),
        .rd_err_i   (rd_err_i),
        .wr_ack_i   (wr_ack_i),
        .wr_err_i   (wr_err_i),
        .sum_next_i (acc_next),
        .acc_clr_o  (acc_clr),
        .acc_add_o  (acc_add),
        .busy_o     (busy_o),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .wr_req_o   (wr_req_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .done_o     (done_o),
        .pass_o     (pass_o),
        .fail_o     (fail_o),
        .rd_fault_o (rd_fault_o),
        .wr_fault_o (wr_fault_o)
    );

    logic unused_sum;
    assign unused_sum = ^acc_sum;

endmodule

// File: rtl/nvm_sum_checker_sva.sv
module nvm_sum_checker_sva #(
    parameter int ADDR_W    = 8,
    parameter int WORD_W    = 16,
    parameter int CSUM_ADDR = 'h3F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              rd_err_i,
    input logic              wr_req_o,
    input logic [WORD_W-1:0] wr_data_o,
    input logic              wr_ack_i,
    input logic              wr_err_i,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o,
    input logic              rd_fault_o,
    input logic              wr_fault_o
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_req_o && !wr_req_o && !done_o));

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_err_i) |=>
            (!rd_req_o || (rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1))));

    a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o <= ADDR_W'(CSUM_ADDR)));

    a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o)));

    a_r5_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req_o && rd_req_o));

    a_r6_read_error_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_err_i) |=>
            (done_o && fail_o && rd_fault_o && !rd_req_o && !wr_req_o));

    a_r7_write_error_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i && wr_err_i) |=> (done_o && fail_o && wr_fault_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o != fail_o));

    a_r8_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=>
            ($stable(pass_o) && $stable(fail_o) && $stable(rd_fault_o) && $stable(wr_fault_o)));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

bind nvm_sum_checker nvm_sum_checker_sva #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .CSUM_ADDR (CSUM_ADDR)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (rd_ack_i),
    .rd_err_i   (rd_err_i),
    .wr_req_o   (wr_req_o),
    .wr_data_o  (wr_data_o),
    .wr_ack_i   (wr_ack_i),
    .wr_err_i   (wr_err_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .rd_fault_o (rd_fault_o),
    .wr_fault_o (wr_fault_o)
);

// File: tb/sim_nvm_sum_checker.sv
module sim_nvm_sum_checker;

    localparam int          ADDR_W = 8;
    localparam int          CSUM   = 'h3F;
    localparam logic [15:0] GOAL   = 16'hBABA;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              mode_i = 1'b0;
    logic              busy_o, rd_req_o, wr_req_o, done_o;
    logic              pass_o, fail_o, rd_fault_o, wr_fault_o;
    logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
    logic [15:0]       wr_data_o;
    logic              rd_ack_i = 1'b0, rd_err_i = 1'b0;
    logic [15:0]       rd_data_i = '0;
    logic              wr_ack_i = 1'b0, wr_err_i = 1'b0;

    always #10 clk = ~clk;

    nvm_sum_checker #(.ADDR_W(ADDR_W), .WORD_W(16), .CSUM_ADDR(CSUM), .TARGET(GOAL)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .busy_o(busy_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .rd_err_i(rd_err_i), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .wr_err_i(wr_err_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
        .rd_fault_o(rd_fault_o), .wr_fault_o(wr_fault_o));

    typedef struct {
        bit          pass;
        bit          fail;
        bit          rdf;
        bit          wrf;
        int          nreads;
        int          nwrites;
        logic [15:0] wdata;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] mem [0:CSUM];
    int          checks = 0, errors = 0;
    int          err_addr = -1, lat = 0, wait_cnt = 0;
    bit          wr_err_inj = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0, exp_addr = 0, ops_done = 0;
    logic [15:0] last_wdata = '0;
    logic [ADDR_W-1:0] last_waddr = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model: answers requests, alternating ack with idle cycles
    always @(negedge clk) begin
        if (rd_ack_i) begin
            rd_ack_i = 1'b0;
            rd_err_i = 1'b0;
        end else if (rd_req_o) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                chk("R2 read address order", 32'(rd_addr_o), 32'(exp_addr));
                rd_data_i = (rd_addr_o <= CSUM) ? mem[rd_addr_o] : 16'h0;
                rd_err_i  = (int'(rd_addr_o) == err_addr);
                rd_ack_i  = 1'b1;
                exp_addr++;
                rd_cnt++;
            end
        end
        if (wr_ack_i) begin
            wr_ack_i = 1'b0;
            wr_err_i = 1'b0;
        end else if (wr_req_o) begin
            last_wdata = wr_data_o;
            last_waddr = wr_addr_o;
            wr_err_i   = wr_err_inj;
            wr_ack_i   = 1'b1;
            wr_cnt++;
            if (!wr_err_inj && wr_addr_o <= CSUM) mem[wr_addr_o] = wr_data_o;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                chk("R8 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " pass"}, 32'(pass_o), 32'(e.pass));
                chk({e.tag, " fail"}, 32'(fail_o), 32'(e.fail));
                chk({e.tag, " rd_fault"}, 32'(rd_fault_o), 32'(e.rdf));
                chk({e.tag, " wr_fault"}, 32'(wr_fault_o), 32'(e.wrf));
                chk({e.tag, " read count"}, 32'(rd_cnt), 32'(e.nreads));
                chk({e.tag, " write count"}, 32'(wr_cnt), 32'(e.nwrites));
                if (e.nwrites > 0) begin
                    chk({e.tag, " write data"}, 32'(last_wdata), 32'(e.wdata));
                    chk({e.tag, " write address"}, 32'(last_waddr), 32'(CSUM));
                end
            end
            ops_done++;
        end
    end

    function automatic logic [15:0] image_sum(input int upto);
        logic [15:0] s = '0;
        for (int i = 0; i <= upto; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic fill(input logic [15:0] base, input logic [15:0] step, input bit fix);
        for (int i = 0; i <= CSUM; i++) mem[i] = base + 16'(i) * step;
        if (fix) mem[CSUM] = GOAL - image_sum(CSUM - 1);
    endtask

    // Driver: computes expectation, pushes it, starts the operation
    task automatic run_op(input string tag, input bit m, input int err_at, input bit wfail,
                          input int lat_i, input bit poke);
        exp_t e;
        int   last;
        int   target_done;
        last = m ? CSUM - 1 : CSUM;
        e.tag = tag;
        e.rdf = (err_at >= 0 && err_at <= last);
        e.nreads = e.rdf ? err_at + 1 : last + 1;
        e.wrf = 1'b0; e.nwrites = 0; e.wdata = '0; e.pass = 1'b0; e.fail = 1'b0;
        if (e.rdf) begin
            e.fail = 1'b1;
        end else if (!m) begin
            e.pass = (image_sum(CSUM) == GOAL);
            e.fail = !e.pass;
        end else begin
            e.nwrites = 1;
            e.wdata = GOAL - image_sum(CSUM - 1);
            e.wrf = wfail;
            e.pass = !wfail;
            e.fail = wfail;
        end
        sb_q.push_back(e);
        err_addr = err_at; wr_err_inj = wfail; lat = lat_i; wait_cnt = 0;
        rd_cnt = 0; wr_cnt = 0; exp_addr = 0;
        target_done = ops_done + 1;
        @(negedge clk);
        start_i = 1'b1; mode_i = m;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (9) @(negedge clk);
            start_i = 1'b1; mode_i = !m;   // R9: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        while (ops_done < target_done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk({"R8 hold pass ", tag}, 32'(pass_o), 32'(e.pass));
        chk({"R8 hold fail ", tag}, 32'(fail_o), 32'(e.fail));
        chk({"R8 done low ", tag}, 32'(done_o), 32'd0);
        chk({"R8 idle after ", tag}, 32'(busy_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        fill(16'h1234, 16'h0101, 1'b1);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 rd_req", 32'(rd_req_o), 32'd0);
        chk("R1 wr_req", 32'(wr_req_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 pass/fail", 32'({pass_o, fail_o, rd_fault_o, wr_fault_o}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op("R3 R10 check valid image", 1'b0, -1, 1'b0, 0, 1'b0);
        mem[10] = mem[10] ^ 16'h0001;
        run_op("R3 check corrupted image", 1'b0, -1, 1'b0, 1, 1'b0);
        fill(16'hF000, 16'h0011, 1'b1);
        run_op("R3 check wraparound image", 1'b0, -1, 1'b0, 2, 1'b0);
        fill(16'h0777, 16'h0913, 1'b0);
        run_op("R3 check garbage image", 1'b0, -1, 1'b0, 0, 1'b0);
        run_op("R4 R5 R10 repair garbage image", 1'b1, -1, 1'b0, 1, 1'b0);
        run_op("R5 check after repair", 1'b0, -1, 1'b0, 0, 1'b0);
        run_op("R6 check read error at 5", 1'b0, 5, 1'b0, 0, 1'b0);
        run_op("R6 repair read error at last word", 1'b1, CSUM - 1, 1'b0, 0, 1'b0);
        run_op("R6 check read error at first word", 1'b0, 0, 1'b0, 1, 1'b0);
        mem[CSUM] = 16'h0000;
        run_op("R7 repair write error", 1'b1, -1, 1'b1, 0, 1'b0);
        run_op("R7 check after failed write", 1'b0, -1, 1'b0, 0, 1'b0);
        run_op("R9 check with start while busy", 1'b0, -1, 1'b0, 1, 1'b1);
        run_op("R9 repair with start while busy", 1'b1, -1, 1'b0, 0, 1'b1);

        repeat (5) @(negedge clk);
        chk("R8 no extra done", 32'(sb_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule